// File: doc/BRIEF.md
# Serial Link Command Framer

This block turns a single register-access request into a framed command and shifts it out on a two-wire link. The master drives the link clock, and the data line is bidirectional. A request carries a read/write flag, an absolute address, a transfer size (8, 16 or 32 bits) and, for writes, the data. The block builds the frame from a start bit, a zeroed target-id field, a direction bit, a size code, the address, the payload on writes and a 4-bit check code. It then sends the frame most significant bit first, one bit per link clock. The data line is active-low on the wire.

The same sequencer produces the link reset pattern on demand. The wire is held low for a first run of link clocks, then high for a long run, then low again. The block does not handle responses or the line turnaround. It raises a one-cycle `done` pulse when the last bit or the last break clock has been sent, and the surrounding logic takes over from there.

Top module: `lnkfrm_top`

## Requirements
- R1: Each frame begins with these logical bits in this order: a start bit of 1, a 2-bit target id of 00, a direction bit (1 = read, 0 = write) and a 2-bit size code. The size code is 00 for `req_size`=0 (8 bits), 01 for `req_size`=1 (16 bits), and 11 for `req_size`=2 or 3 (32 bits). The address follows, most significant bit first.
- R2: A write frame carries the low 8, 16 or 32 bits of `req_wdata` right after the address, most significant bit first. A read frame carries no payload.
- R3: Four check bits end the frame. They are the remainder of x^4+x+1, seeded with zero, over every bit from the start bit through the last payload bit, and are sent most significant bit first.
- R4: While a frame is sent, `lnk_dat` is the inverse of the logical bit and `lnk_oe` is 1. When idle, `lnk_oe`=0, `lnk_dat`=1 and `lnk_clk`=0.
- R5: Each link bit takes two system cycles, with `lnk_clk` low in the first and high in the second. `lnk_dat` keeps the same value across both cycles.
- R6: `busy` rises in the cycle after a request is accepted and stays high until `done`. A `req_valid` or `brk_req` that arrives while `busy` is high is ignored.
- R7: `done` is a single-cycle pulse. For a frame of N bits, including the check bits, it is high 2N+1 cycles after the clock edge that accepted the request.
- R8: A break request drives the wire low for PRE_CLKS link clocks, then high for BRK_CLKS, then low for POST_CLKS, and `done` follows the last clock. When `brk_req` and `req_valid` are both high in the same idle cycle, the break is served.
- R9: After reset, `busy`, `done`, `lnk_clk` and `lnk_oe` are 0 and `lnk_dat` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 8 bits, 1 = 16 bits, 2/3 = 32 bits |
| req_addr | input | ADDR_W | Absolute address |
| req_wdata | input | 32 | Write data, low bits used |
| brk_req | input | 1 | Request for the break pattern |
| busy | output | 1 | Frame or break in progress |
| done | output | 1 | One-cycle completion pulse |
| lnk_clk | output | 1 | Link clock |
| lnk_dat | output | 1 | Link data, active-low |
| lnk_oe | output | 1 | Data line drive enable |

## Verification
Timing is counted from the falling system-clock edge that follows the accepting edge, which is cycle 1. Link bit i is read in cycle 2i+2, where `lnk_clk` is high. For a frame of N bits, `done` is due in cycle 2N+1. For the break it is due in cycle 2(PRE_CLKS+BRK_CLKS+POST_CLKS)+1. The bench samples only on falling edges and compares each captured bit and the `done` cycle number against a frame and check code rebuilt from the requirements. It also checks that a request injected mid-frame leaves the frame unchanged.

// File: rtl/lnkfrm_pkg.sv
package lnkfrm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_CRC,
        ST_PRE,
        ST_BRK,
        ST_POST
    } seq_e;

    localparam int unsigned CHK_W   = 4;
    localparam logic [3:0]  CHK_TAP = 4'b0011;
endpackage

// File: rtl/lnkfrm_build.sv
module lnkfrm_build #(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned HW     = 6 + ADDR_W,
    parameter int unsigned FW     = HW + 32,
    parameter int unsigned CW     = 7
) (
    input  logic              wr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [FW-1:0]     img,
    output logic [CW-1:0]     nbits
);
    logic [1:0]    code;
    logic [CW-1:0] pay_bits;
    logic [31:0]   pay;

    always_comb begin
        case (size)
            2'd0: begin
                code     = 2'b00;
                pay_bits = CW'(8);
                pay      = {wdata[7:0], 24'b0};
            end
            2'd1: begin
                code     = 2'b01;
                pay_bits = CW'(16);
                pay      = {wdata[15:0], 16'b0};
            end
            default: begin
                code     = 2'b11;
                pay_bits = CW'(32);
                pay      = wdata;
            end
        endcase
        if (!wr) begin
            pay = '0;
        end
        img   = {1'b1, 2'b00, ~wr, code, addr, pay};
        nbits = CW'(HW) + (wr ? pay_bits : '0);
    end
endmodule

// File: rtl/lnkfrm_crc4.sv
module lnkfrm_crc4
    import lnkfrm_pkg::*;
(
    input  logic [CHK_W-1:0] crc_i,
    input  logic             bit_i,
    output logic [CHK_W-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = crc_i[CHK_W-1] ^ bit_i;
        crc_o = {crc_i[CHK_W-2:0], 1'b0} ^ (fb ? CHK_TAP : '0);
    end
endmodule

// File: rtl/lnkfrm_pins.sv
module lnkfrm_pins
    import lnkfrm_pkg::*;
(
    input  seq_e st,
    input  logic ph,
    input  logic lbit,
    output logic lclk,
    output logic ldat,
    output logic loe
);
    always_comb begin
        lclk = ph;
        loe  = 1'b1;
        case (st)
            ST_DATA, ST_CRC: ldat = ~lbit;
            ST_PRE, ST_POST: ldat = 1'b0;
            ST_BRK:          ldat = 1'b1;
            default: begin
                ldat = 1'b1;
                lclk = 1'b0;
                loe  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lnkfrm_top.sv
module lnkfrm_top
    import lnkfrm_pkg::*;
#(
    parameter int unsigned ADDR_W    = 21,
    parameter int unsigned PRE_CLKS  = 16,
    parameter int unsigned BRK_CLKS  = 256,
    parameter int unsigned POST_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              brk_req,
    output logic              busy,
    output logic              done,
    output logic              lnk_clk,
    output logic              lnk_dat,
    output logic              lnk_oe
);
    localparam int unsigned HW    = 6 + ADDR_W;
    localparam int unsigned FW    = HW + 32;
    localparam int unsigned MAXA  = (FW > PRE_CLKS) ? FW : PRE_CLKS;
    localparam int unsigned MAXB  = (BRK_CLKS > POST_CLKS) ? BRK_CLKS : POST_CLKS;
    localparam int unsigned MAXC  = (MAXA > MAXB) ? MAXA : MAXB;
    localparam int unsigned CW    = $clog2(MAXC + 1);

    typedef struct packed {
        seq_e              st;
        logic [FW-1:0]     sh;
        logic [CW-1:0]     cnt;
        logic [CHK_W-1:0]  crc;
        logic              ph;
        logic              done;
    } seq_t;

    seq_t r_d, r_q;

    logic [FW-1:0]    img;
    logic [CW-1:0]    nbits;
    logic             bit_now;
    logic [CHK_W-1:0] crc_nx;

    lnkfrm_build #(.ADDR_W(ADDR_W), .HW(HW), .FW(FW), .CW(CW)) u_build (
        .wr    (req_write),
        .size  (req_size),
        .addr  (req_addr),
        .wdata (req_wdata),
        .img   (img),
        .nbits (nbits)
    );

    assign bit_now = (r_q.st == ST_CRC) ? r_q.crc[CHK_W-1] : r_q.sh[FW-1];

    lnkfrm_crc4 u_crc (
        .crc_i (r_q.crc),
        .bit_i (r_q.sh[FW-1]),
        .crc_o (crc_nx)
    );

    lnkfrm_pins u_pins (
        .st   (r_q.st),
        .ph   (r_q.ph),
        .lbit (bit_now),
        .lclk (lnk_clk),
        .ldat (lnk_dat),
        .loe  (lnk_oe)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.ph = 1'b0;
                if (brk_req) begin
                    r_d.st  = ST_PRE;
                    r_d.cnt = CW'(PRE_CLKS - 1);
                end else if (req_valid) begin
                    r_d.st  = ST_DATA;
                    r_d.sh  = img;
                    r_d.cnt = nbits - CW'(1);
                    r_d.crc = '0;
                end
            end
            ST_DATA: begin
                r_d.ph = ~r_q.ph;
                if (r_q.ph) begin
                    r_d.crc = crc_nx;
                    r_d.sh  = r_q.sh << 1;
                    if (r_q.cnt == '0) begin
                        r_d.st  = ST_CRC;
                        r_d.cnt = CW'(CHK_W - 1);
                    end else begin
                        r_d.cnt = r_q.cnt - CW'(1);
                    end
                end
            end
            ST_CRC: begin
                r_d.ph = ~r_q.ph;
                if (r_q.ph) begin
                    r_d.crc = r_q.crc << 1;
                    if (r_q.cnt == '0) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt - CW'(1);
                    end
                end
            end
            ST_PRE, ST_BRK, ST_POST: begin
                r_d.ph = ~r_q.ph;
                if (r_q.ph) begin
                    if (r_q.cnt != '0) begin
                        r_d.cnt = r_q.cnt - CW'(1);
                    end else if (r_q.st == ST_PRE) begin
                        r_d.st  = ST_BRK;
                        r_d.cnt = CW'(BRK_CLKS - 1);
                    end else if (r_q.st == ST_BRK) begin
                        r_d.st  = ST_POST;
                        r_d.cnt = CW'(POST_CLKS - 1);
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
                r_d.ph = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, sh: '0, cnt: '0, crc: '0, ph: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != ST_IDLE);
    assign done = r_q.done;

    // R7: done lasts one cycle and only ends a busy period
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    // R5: link clock high for one cycle, data steady across a bit
    assert_clk_high_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_clk |=> !lnk_clk);
    assert_dat_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !lnk_clk) |=> $stable(lnk_dat));
    // R6: a busy period starts only from a request
    assert_busy_from_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid || brk_req));
    // R8: high phase of break entered only from the first low phase
    assert_break_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BRK && $past(r_q.st) != ST_BRK) |-> $past(r_q.st) == ST_PRE);
endmodule

// File: tb/tb_lnkfrm_top.sv
module tb_lnkfrm_top;
    localparam int ADDR_W = 21;
    localparam int HW     = 6 + ADDR_W;
    localparam int PRE    = 16;
    localparam int BRK    = 256;
    localparam int POST   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              brk_req = 1'b0;
    logic busy, done, lnk_clk, lnk_dat, lnk_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    bit exp_bits [0:127];
    int exp_n;
    bit cap [0:1023];

    always #5 clk = ~clk;

    lnkfrm_top #(.ADDR_W(ADDR_W), .PRE_CLKS(PRE), .BRK_CLKS(BRK), .POST_CLKS(POST)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .brk_req(brk_req), .busy(busy), .done(done), .lnk_clk(lnk_clk),
        .lnk_dat(lnk_dat), .lnk_oe(lnk_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pay_len(input bit [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    task automatic make_exp(input bit wr, input bit [1:0] sz,
                            input bit [ADDR_W-1:0] a, input bit [31:0] d);
        bit [1:0] code;
        bit [3:0] c;
        int pl;
        code = (sz == 2'd0) ? 2'b00 : (sz == 2'd1) ? 2'b01 : 2'b11;
        pl = pay_len(sz);
        exp_n = 0;
        exp_bits[exp_n++] = 1'b1;
        exp_bits[exp_n++] = 1'b0;
        exp_bits[exp_n++] = 1'b0;
        exp_bits[exp_n++] = ~wr;
        exp_bits[exp_n++] = code[1];
        exp_bits[exp_n++] = code[0];
        for (int i = ADDR_W - 1; i >= 0; i--) exp_bits[exp_n++] = a[i];
        if (wr) for (int i = pl - 1; i >= 0; i--) exp_bits[exp_n++] = d[i];
        c = 4'h0;
        for (int i = 0; i < exp_n; i++) begin
            bit fb;
            fb = c[3] ^ exp_bits[i];
            c = {c[2:0], 1'b0};
            if (fb) c = c ^ 4'b0011;
        end
        for (int i = 3; i >= 0; i--) exp_bits[exp_n++] = c[i];
    endtask

    task automatic run_frame(input bit wr, input bit [1:0] sz, input bit [ADDR_W-1:0] a,
                             input bit [31:0] d, input bit inject);
        int ncap, cyc, done_cyc, bad_oe, bad_stab, bad_busy;
        int bad_hdr, bad_pay, bad_crc;
        bit prev_dat;
        make_exp(wr, sz, a, d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R6", "busy after accept", busy, 1);
        ncap = 0; cyc = 1; done_cyc = -1; bad_oe = 0; bad_stab = 0; bad_busy = 0;
        prev_dat = lnk_dat;
        while (done_cyc < 0 && cyc < 2000) begin
            if (done) begin
                done_cyc = cyc;
            end else begin
                if (!busy) bad_busy++;
                if (!lnk_oe) bad_oe++;
                if (lnk_clk) begin
                    if (lnk_dat != prev_dat) bad_stab++;
                    cap[ncap] = ~lnk_dat;
                    ncap++;
                end
                prev_dat = lnk_dat;
            end
            if (inject && cyc == 5) begin
                req_valid = 1'b1; brk_req = 1'b1; req_write = ~wr;
                req_addr = ~a; req_wdata = ~d; req_size = sz + 2'd1;
            end
            if (inject && cyc == 6) begin
                req_valid = 1'b0; brk_req = 1'b0;
            end
            if (done_cyc < 0) begin
                @(negedge clk);
                cyc++;
            end
        end
        bad_hdr = 0; bad_pay = 0; bad_crc = 0;
        for (int i = 0; i < exp_n && i < ncap; i++) begin
            if (cap[i] != exp_bits[i]) begin
                if (i < HW) bad_hdr++;
                else if (i >= exp_n - 4) bad_crc++;
                else bad_pay++;
            end
        end
        chk(ncap == exp_n, "R2", "frame bit count", ncap, exp_n);
        chk(bad_hdr == 0, "R1", "header bit mismatches", bad_hdr, 0);
        chk(bad_pay == 0, "R2", "payload bit mismatches", bad_pay, 0);
        chk(bad_crc == 0, "R3", "check bit mismatches", bad_crc, 0);
        chk(done_cyc == 2 * exp_n + 1, "R7", "done cycle", done_cyc, 2 * exp_n + 1);
        chk(bad_oe == 0, "R4", "oe low during frame", bad_oe, 0);
        chk(bad_stab == 0, "R5", "data change at clock high", bad_stab, 0);
        chk(bad_busy == 0, "R6", "busy low before done", bad_busy, 0);
        if (inject) chk(bad_hdr + bad_pay + bad_crc == 0, "R6", "frame disturbed by request while busy",
                        bad_hdr + bad_pay + bad_crc, 0);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done longer than one cycle", done, 0);
        chk(lnk_oe == 1'b0 && lnk_dat == 1'b1 && lnk_clk == 1'b0, "R4", "idle line {oe,dat,clk}",
            {lnk_oe, lnk_dat, lnk_clk}, 3'b010);
    endtask

    task automatic run_break();
        int cyc, done_cyc, k, bad_lvl, bad_oe;
        bit exp_lvl;
        @(negedge clk);
        brk_req = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2;
        @(negedge clk);
        brk_req = 1'b0; req_valid = 1'b0;
        cyc = 1; done_cyc = -1; k = 0; bad_lvl = 0; bad_oe = 0;
        while (done_cyc < 0 && cyc < 4000) begin
            if (done) begin
                done_cyc = cyc;
            end else begin
                if (!lnk_oe) bad_oe++;
                if (lnk_clk) begin
                    exp_lvl = (k >= PRE && k < PRE + BRK);
                    if (lnk_dat != exp_lvl) bad_lvl++;
                    k++;
                end
                @(negedge clk);
                cyc++;
            end
        end
        chk(k == PRE + BRK + POST, "R8", "break clock count", k, PRE + BRK + POST);
        chk(bad_lvl == 0, "R8", "break wire level mismatches", bad_lvl, 0);
        chk(bad_oe == 0, "R8", "oe low during break", bad_oe, 0);
        chk(done_cyc == 2 * (PRE + BRK + POST) + 1, "R8", "break done cycle",
            done_cyc, 2 * (PRE + BRK + POST) + 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({busy, done, lnk_clk, lnk_oe, lnk_dat} == 5'b00001, "R9",
            "reset {busy,done,clk,oe,dat}", {busy, done, lnk_clk, lnk_oe, lnk_dat}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && lnk_oe == 1'b0, "R9", "idle after reset", busy, 0);
        // directed corners
        run_frame(1'b0, 2'd0, '0, 32'h0, 1'b0);
        run_frame(1'b1, 2'd0, '1, 32'hFFFF_FFA5, 1'b0);
        run_frame(1'b1, 2'd1, 21'h15555, 32'h1234_BEEF, 1'b0);
        run_frame(1'b1, 2'd3, 21'h0ABCD, 32'hDEAD_BEEF, 1'b0);
        run_frame(1'b0, 2'd2, 21'h1FFFF, 32'hFFFF_FFFF, 1'b1);
        run_frame(1'b1, 2'd2, 21'h00001, 32'h8000_0001, 1'b1);
        run_break();
        // constrained random
        for (int n = 0; n < 40; n++) begin
            run_frame(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                      ADDR_W'($urandom), $urandom, (n % 7) == 3);
        end
        run_frame(1'b1, 2'd0, 21'h00F0F, 32'h0000_005A, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule